// File: doc/BRIEF.md
# Chip-Select Unit with E-Clock Stretching

This block drives the four active-low chip-select outputs of a microcontroller's external bus: I/O, general 1, general 2 and program. It also generates the external E clock. The address decoders sit outside. The block receives one match flag per region and three fold controls. The fold controls let the general-1 and general-2 regions reuse the program output or the general-2 output in place of their own pins, so a board can wire fewer devices.

Each region has a two-bit stretch count in an 8-bit register. An access that falls in that region keeps E high for that many extra full E periods. During those periods the bus-hold flag is raised. The internal clock is never gated: stretching only lengthens the external E cycle. The select outputs and the stretch choice are captured at the E falling edge that opens each access. They then stay fixed until the next such edge, so the pins never glitch.

The reset value of the stretch register depends on a mode pin. In normal mode every program access gets one extra E period. In special mode no access is stretched.

Top module: `cs_stretch_unit`

## Requirements
- R1: While reset is asserted and directly after it is released, all four select outputs are high (inactive), `e_clk` is low and `bus_hold` is low.
- R2: The I/O select asserts (low) for exactly the accesses whose I/O match flag was set, whatever the fold controls are.
- R3: With `fold_g2_prog` set, `cs_prog_n` asserts for program or general-2 matches and `cs_gp2_n` never asserts. Every general-2 match asserts either `cs_gp2_n` or `cs_prog_n`.
- R4: With `fold_g1_prog` set, `cs_prog_n` asserts for program or general-1 matches and `cs_gp1_n` never asserts. In this case `fold_g1_g2` has no effect.
- R5: `fold_g1_g2` takes effect only when both other fold controls are clear. `cs_gp2_n` then asserts for general-2 or general-1 matches and `cs_gp1_n` never asserts. If `fold_g2_prog` is set and `fold_g1_prog` is clear, general 1 keeps its own output.
- R6: E is low for `HALF_PER` clocks and high for `HALF_PER*(1+2*s)` clocks, where s is the stretch count of the access.
- R7: The stretch register holds four 2-bit counts (value = number of extra E periods). I/O uses bits 7:6, general 1 uses bits 5:4, general 2 uses bits 3:2 and program uses bits 1:0.
- R8: The stretch count comes from the region that matched, even when that region is folded onto another output. With several matches the order is I/O, then program, then general 1, then general 2. With no match the stretch is zero.
- R9: `bus_hold` is high exactly during the extra E-high periods (`2*HALF_PER*s` clocks) and falls together with E.
- R10: After reset the stretch register reads 0x01 (one-period program stretch) when `mode_special` is low, and 0x00 when it is high.
- R11: The select outputs change only at the clock edge where E falls. Match-flag or fold-control changes during an E cycle do not disturb them.
- R12: A register write applies to every access whose E-high phase starts after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_special | input | 1 | Chooses the stretch register reset value (1 = no program stretch) |
| hit_io | input | 1 | Address matches the I/O region |
| hit_gp1 | input | 1 | Address matches the general-1 region |
| hit_gp2 | input | 1 | Address matches the general-2 region |
| hit_prog | input | 1 | Address matches the program region |
| fold_g1_g2 | input | 1 | Send general-1 matches to the general-2 output |
| fold_g1_prog | input | 1 | Send general-1 matches to the program output |
| fold_g2_prog | input | 1 | Send general-2 matches to the program output |
| str_wr_en | input | 1 | Stretch register write strobe |
| str_wr_data | input | 8 | Stretch register write value |
| cs_io_n | output | 1 | I/O chip select, active low |
| cs_gp1_n | output | 1 | General-1 chip select, active low |
| cs_gp2_n | output | 1 | General-2 chip select, active low |
| cs_prog_n | output | 1 | Program chip select, active low |
| e_clk | output | 1 | External E clock |
| bus_hold | output | 1 | High while E is held high by a stretch |

## Verification
The bench builds the block with `HALF_PER` = 2, so a plain E cycle takes four clocks. This keeps a sweep of all 8 fold-control settings against all 16 match patterns short. Each of those 128 accesses also changes its inputs mid-cycle to test that the selects stay put. With the same setting, every stretch count of every region fits in the run and each is measured to the clock. This includes folded sources, the priority order and both reset modes.

// File: rtl/csu_pkg.sv
// Package: shared constants and types for the chip-select / E-stretch unit.
// Assumes four selects with 2-bit stretch fields packed into one byte.
package csu_pkg;
    localparam int NUM_SEL = 4;
    localparam int STR_W   = 2;
    localparam int REG_W   = NUM_SEL * STR_W;

    // Field index inside the stretch register (index i sits at bits 2i+1:2i).
    typedef enum logic [1:0] {
        SEL_PROG = 2'd0,
        SEL_GP2  = 2'd1,
        SEL_GP1  = 2'd2,
        SEL_IO   = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        PH_LOW  = 2'd0,
        PH_HIGH = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic io;
        logic gp1;
        logic gp2;
        logic prog;
    } sel_vec_t;

    typedef struct packed {
        logic g1_onto_g2;
        logic g1_onto_prog;
        logic g2_onto_prog;
    } fold_t;
endpackage

// File: rtl/csu_stretch_reg.sv
// Stretch register: holds one stretch count per select and unpacks them.
// Assumes a full-byte write strobe; the reset value depends on the mode pin.
module csu_stretch_reg
    import csu_pkg::*;
#(
    parameter int N_SEL  = NUM_SEL,
    parameter int FLD_W  = STR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_special,
    input  logic                        wr_en,
    input  logic [N_SEL*FLD_W-1:0]      wr_data,
    output logic [N_SEL-1:0][FLD_W-1:0] field_o
);
    localparam int RW = N_SEL * FLD_W;

    logic [RW-1:0] reg_q;

    // Register update: mode-dependent reset value, otherwise full-byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= mode_special ? '0 : RW'(1);
        end else if (wr_en) begin
            reg_q <= wr_data;
        end
    end

    // Split the register into per-select fields.
    for (genvar gi = 0; gi < N_SEL; gi++) begin : g_field
        assign field_o[gi] = reg_q[gi*FLD_W +: FLD_W];
    end

    // R10
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (reg_q == ($past(mode_special) ? '0 : RW'(1))));
endmodule

// File: rtl/csu_fold.sv
// Fold logic: routes per-region matches onto select outputs under the
// three fold controls. Program-folds take priority over the general fold.
// Pure combinational; assumes the caller registers the result.
module csu_fold
    import csu_pkg::*;
(
    input  sel_vec_t hit,
    input  fold_t    ctl,
    output sel_vec_t act
);
    logic g1_to_prog;
    logic g1_to_g2;
    logic g2_to_prog;

    // Decide where each general region is routed.
    always_comb begin
        g2_to_prog = ctl.g2_onto_prog;
        g1_to_prog = ctl.g1_onto_prog;
        g1_to_g2   = ctl.g1_onto_g2 && !ctl.g1_onto_prog && !ctl.g2_onto_prog;
    end

    // Build the active-high output vector from the routing.
    always_comb begin
        act.io   = hit.io;
        act.prog = hit.prog | (g1_to_prog & hit.gp1) | (g2_to_prog & hit.gp2);
        act.gp2  = !g2_to_prog & (hit.gp2 | (g1_to_g2 & hit.gp1));
        act.gp1  = !(g1_to_prog | g1_to_g2 | (ctl.g1_onto_g2 & !g2_to_prog)) & hit.gp1;
    end
endmodule

// File: rtl/csu_etiming.sv
// E-clock sequencer: low half, high half, then whole stretch periods with E
// held high. The stretch count is loaded when E rises and counts down per
// extra period. 'boundary' marks the clock edge at which E falls.
// Assumes HALF_PER >= 1; the internal clock is never gated.
module csu_etiming
    import csu_pkg::*;
#(
    parameter int HALF_PER = 2,
    parameter int FLD_W    = STR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLD_W-1:0] stretch_in,
    output logic             e_clk,
    output logic             bus_hold,
    output logic             boundary
);
    localparam int CNT_W = (2 * HALF_PER > 1) ? $clog2(2 * HALF_PER) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_PER - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(2 * HALF_PER - 1);

    phase_e             ph;
    logic [CNT_W-1:0]   cnt;
    logic [FLD_W-1:0]   rem;
    logic [CNT_W:0]     low_run;

    // Strobe for the edge at which E leaves the high/held state.
    always_comb begin
        boundary = ((ph == PH_HIGH) && (cnt == HALF_LAST) && (rem == '0)) ||
                   ((ph == PH_HOLD) && (cnt == FULL_LAST) && (rem == FLD_W'(1)));
    end

    // Phase sequencer with stretch down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_LOW;
            cnt <= '0;
            rem <= '0;
        end else begin
            case (ph)
                PH_LOW: begin
                    if (cnt == HALF_LAST) begin
                        ph  <= PH_HIGH;
                        cnt <= '0;
                        rem <= stretch_in;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        ph  <= (rem == '0) ? PH_LOW : PH_HOLD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == FULL_LAST) begin
                        cnt <= '0;
                        rem <= rem - FLD_W'(1);
                        if (rem == FLD_W'(1)) ph <= PH_LOW;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    ph  <= PH_LOW;
                    cnt <= '0;
                end
            endcase
        end
    end

    assign e_clk    = (ph != PH_LOW);
    assign bus_hold = (ph == PH_HOLD);

    // Checker counter: length of the current low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      low_run <= '0;
        else if (!e_clk) low_run <= low_run + (CNT_W+1)'(1);
        else             low_run <= '0;
    end

    // R6
    low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_clk) |-> (low_run == (CNT_W+1)'(HALF_PER)));

    // R9
    hold_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_hold) |-> $fell(e_clk));
endmodule

// File: rtl/cs_stretch_unit.sv
// Chip-select unit top: captures match flags and fold controls at each E
// falling edge, drives the four active-low selects from that capture, and
// picks the stretch count of the matched source region for the E sequencer.
// Assumes match flags are valid at the clock edge where E falls.
module cs_stretch_unit
    import csu_pkg::*;
#(
    parameter int HALF_PER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_special,
    input  logic             hit_io,
    input  logic             hit_gp1,
    input  logic             hit_gp2,
    input  logic             hit_prog,
    input  logic             fold_g1_g2,
    input  logic             fold_g1_prog,
    input  logic             fold_g2_prog,
    input  logic             str_wr_en,
    input  logic [REG_W-1:0] str_wr_data,
    output logic             cs_io_n,
    output logic             cs_gp1_n,
    output logic             cs_gp2_n,
    output logic             cs_prog_n,
    output logic             e_clk,
    output logic             bus_hold
);
    sel_vec_t                       hit_raw;
    fold_t                          ctl_raw;
    sel_vec_t                       act_next;
    sel_vec_t                       cs_act;
    sel_vec_t                       hit_lat;
    logic [NUM_SEL-1:0][STR_W-1:0]  fields;
    logic [STR_W-1:0]               pick;
    logic                           boundary;

    assign hit_raw = '{io: hit_io, gp1: hit_gp1, gp2: hit_gp2, prog: hit_prog};
    assign ctl_raw = '{g1_onto_g2: fold_g1_g2, g1_onto_prog: fold_g1_prog,
                       g2_onto_prog: fold_g2_prog};

    csu_stretch_reg #(.N_SEL(NUM_SEL), .FLD_W(STR_W)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_special (mode_special),
        .wr_en        (str_wr_en),
        .wr_data      (str_wr_data),
        .field_o      (fields)
    );

    csu_fold u_fold (
        .hit (hit_raw),
        .ctl (ctl_raw),
        .act (act_next)
    );

    csu_etiming #(.HALF_PER(HALF_PER), .FLD_W(STR_W)) u_etim (
        .clk        (clk),
        .rst_n      (rst_n),
        .stretch_in (pick),
        .e_clk      (e_clk),
        .bus_hold   (bus_hold),
        .boundary   (boundary)
    );

    // Capture selects and source matches once per E cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_act  <= '0;
            hit_lat <= '0;
        end else if (boundary) begin
            cs_act  <= act_next;
            hit_lat <= hit_raw;
        end
    end

    // Stretch count of the matched source region, by fixed priority.
    always_comb begin
        pick = '0;
        if (hit_lat.io)        pick = fields[int'(SEL_IO)];
        else if (hit_lat.prog) pick = fields[int'(SEL_PROG)];
        else if (hit_lat.gp1)  pick = fields[int'(SEL_GP1)];
        else if (hit_lat.gp2)  pick = fields[int'(SEL_GP2)];
    end

    assign cs_io_n   = ~cs_act.io;
    assign cs_gp1_n  = ~cs_act.gp1;
    assign cs_gp2_n  = ~cs_act.gp2;
    assign cs_prog_n = ~cs_act.prog;

    // R11
    cs_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(cs_act) |-> $fell(e_clk));

    // R3
    gp2_reaches_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lat.gp2 |-> (cs_act.gp2 || cs_act.prog));

    // R5
    gp1_reaches_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lat.gp1 |-> (cs_act.gp1 || cs_act.gp2 || cs_act.prog));
endmodule

// File: tb/test_cs_stretch_unit.sv
module test_cs_stretch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_special = 1'b0;
    logic       hit_io = 0, hit_gp1 = 0, hit_gp2 = 0, hit_prog = 0;
    logic       fold_g1_g2 = 0, fold_g1_prog = 0, fold_g2_prog = 0;
    logic       str_wr_en = 0;
    logic [7:0] str_wr_data = '0;
    logic       cs_io_n, cs_gp1_n, cs_gp2_n, cs_prog_n, e_clk, bus_hold;

    int checks = 0;
    int errors = 0;

    cs_stretch_unit #(.HALF_PER(HALF)) i_cs_stretch_unit (
        .clk, .rst_n, .mode_special,
        .hit_io, .hit_gp1, .hit_gp2, .hit_prog,
        .fold_g1_g2, .fold_g1_prog, .fold_g2_prog,
        .str_wr_en, .str_wr_data,
        .cs_io_n, .cs_gp1_n, .cs_gp2_n, .cs_prog_n,
        .e_clk, .bus_hold
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected active-high selects {io,gp1,gp2,prog}; f = {g1_g2,g1_prog,g2_prog}.
    function automatic logic [3:0] exp_cs(input logic [3:0] m, input logic [2:0] f);
        logic [3:0] a;
        int d1, d2;
        a = '0;
        d2 = f[0] ? 0 : 1;
        if (f[1])               d1 = 0;
        else if (f[2] && !f[0]) d1 = 1;
        else                    d1 = 2;
        a[3]  = m[3];
        a[0]  = a[0] | m[0];
        a[d2] = a[d2] | m[1];
        a[d1] = a[d1] | m[2];
        return a;
    endfunction

    // Expected stretch: priority io, prog, gp1, gp2; fields io 7:6 gp1 5:4 gp2 3:2 prog 1:0.
    function automatic int exp_str(input logic [3:0] m, input logic [7:0] r);
        if (m[3]) return int'(r[7:6]);
        if (m[0]) return int'(r[1:0]);
        if (m[2]) return int'(r[5:4]);
        if (m[1]) return int'(r[3:2]);
        return 0;
    endfunction

    function automatic logic [3:0] cs_now();
        return ~{cs_io_n, cs_gp1_n, cs_gp2_n, cs_prog_n};
    endfunction

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        str_wr_en = 1'b1;
        str_wr_data = v;
        @(negedge clk);
        str_wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic special);
        @(negedge clk);
        rst_n = 1'b0;
        mode_special = special;
        repeat (3) @(negedge clk);
        check_eq("R1", "cs during reset", int'(cs_now()), 0);
        check_eq("R1", "e during reset", int'(e_clk), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "cs after reset", int'(cs_now()), 0);
        check_eq("R1", "e/hold after reset", int'({e_clk, bus_hold}), 0);
    endtask

    // One access: apply inputs, wait for E fall, then scramble inputs and measure.
    task automatic access(input logic [3:0] m, input logic [2:0] f,
                          output logic [3:0] seen, output int lo_w, output int hi_w,
                          output int hold_w, output bit stable);
        logic prev;
        {hit_io, hit_gp1, hit_gp2, hit_prog} = m;
        {fold_g1_g2, fold_g1_prog, fold_g2_prog} = f;
        prev = e_clk;
        while (1) begin
            @(negedge clk);
            if (prev && !e_clk) break;
            prev = e_clk;
        end
        seen = cs_now();
        {hit_io, hit_gp1, hit_gp2, hit_prog} = ~m;
        {fold_g1_g2, fold_g1_prog, fold_g2_prog} = ~f;
        stable = 1'b1;
        lo_w = 1; hi_w = 0; hold_w = 0;
        while (1) begin
            @(negedge clk);
            if (e_clk) begin
                hi_w++;
                if (bus_hold) hold_w++;
            end else if (hi_w > 0) begin
                break;
            end else begin
                lo_w++;
            end
            if (cs_now() != seen) stable = 1'b0;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] seen;
        int lo, hi, hd;
        bit st;
        logic [7:0] rv;

        // R1, R10: normal-mode reset gives a one-period program stretch.
        do_reset(1'b0);
        access(4'b0001, 3'b000, seen, lo, hi, hd, st);
        check_eq("R10", "normal-mode prog high width", hi, HALF * 3);
        check_eq("R9", "normal-mode prog hold width", hd, 2 * HALF);
        access(4'b0010, 3'b000, seen, lo, hi, hd, st);
        check_eq("R10", "normal-mode gp2 high width", hi, HALF);

        // R10: special-mode reset clears every stretch.
        do_reset(1'b1);
        access(4'b0001, 3'b000, seen, lo, hi, hd, st);
        check_eq("R10", "special-mode prog high width", hi, HALF);

        // R2-R6, R11: full sweep of fold controls against match patterns.
        for (int f = 0; f < 8; f++) begin
            for (int m = 0; m < 16; m++) begin
                string tag;
                tag = (f[1]) ? "R4" : (f[0]) ? "R3" : (f[2]) ? "R5" : "R2";
                access(4'(m), 3'(f), seen, lo, hi, hd, st);
                check_eq(tag, $sformatf("selects f=%0d m=%0d", f, m),
                         int'(seen), int'(exp_cs(4'(m), 3'(f))));
                check_eq("R2", "io select follows io match", int'(seen[3]), int'(m[3]));
                check_eq("R11", "selects held through cycle", int'(st), 1);
                check_eq("R6", "low width", lo, HALF);
                check_eq("R6", "unstretched high width", hi, HALF);
                check_eq("R9", "no hold without stretch", hd, 0);
            end
        end

        // R7, R9, R12: every count in every field, other fields set differently.
        for (int r = 0; r < 4; r++) begin
            for (int s = 0; s < 4; s++) begin
                rv = '0;
                for (int k = 0; k < 4; k++) rv[2*k +: 2] = (k == r) ? 2'(s) : 2'(3 - s);
                write_reg(rv);
                access(4'(1 << r), 3'b000, seen, lo, hi, hd, st);
                check_eq("R7", $sformatf("high width region %0d count %0d", r, s),
                         hi, HALF * (1 + 2 * s));
                check_eq("R9", $sformatf("hold width region %0d count %0d", r, s),
                         hd, 2 * HALF * s);
                check_eq("R12", "written count used by next access", hi - HALF, 2 * HALF * s);
            end
        end

        // R8: folded sources keep their own count; priority; no match.
        write_reg(8'h20);
        access(4'b0100, 3'b010, seen, lo, hi, hd, st);
        check_eq("R8", "gp1 folded onto prog uses gp1 count", hi, HALF * (1 + 2 * exp_str(4'b0100, 8'h20)));
        check_eq("R4", "gp1 folded shows on prog", int'(seen), 4'b0001);
        write_reg(8'h0C);
        access(4'b0010, 3'b001, seen, lo, hi, hd, st);
        check_eq("R8", "gp2 folded onto prog uses gp2 count", hi, HALF * 7);
        write_reg(8'h1C);
        access(4'b0100, 3'b100, seen, lo, hi, hd, st);
        check_eq("R8", "gp1 folded onto gp2 uses gp1 count", hi, HALF * 3);
        write_reg(8'hFF);
        access(4'b0000, 3'b000, seen, lo, hi, hd, st);
        check_eq("R8", "no match no stretch", hi, HALF);
        check_eq("R9", "no match no hold", hd, 0);
        write_reg(8'h81);
        access(4'b1001, 3'b000, seen, lo, hi, hd, st);
        check_eq("R8", "io wins over prog", hi, HALF * (1 + 2 * exp_str(4'b1001, 8'h81)));
        write_reg(8'h30);
        access(4'b0101, 3'b000, seen, lo, hi, hd, st);
        check_eq("R8", "prog wins over gp1", hi, HALF);
        write_reg(8'h1C);
        access(4'b0110, 3'b000, seen, lo, hi, hd, st);
        check_eq("R8", "gp1 wins over gp2", hi, HALF * 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule